// File: doc/BRIEF.md
# YUV to RGB Colour Space Converter

This block turns a stream of 8-bit luma/chroma pixels into 8-bit red, green and blue. It takes one pixel per clock through a valid/ready handshake. Each output channel is a programmable affine function of Y, U and V: three matrix gains and an additive offset per channel, twelve values in all. The values sit in a small write-only coefficient bank that is loaded through a simple register port.

Each pixel carries a bypass flag. When the flag is set, the pixel skips the matrix and its three components appear unchanged on the outputs. The pipeline has three register stages. A pixel takes the same number of cycles in both modes, so converted and bypassed pixels can be mixed freely in one stream. When the consumer holds ready low, the whole pipeline stalls in place.

Top module: `yuv_rgb_csc`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Reset loads a limited-range BT.601 matrix. The luma gain 0x4A7 sits in column 0 of every row. The G row has U gain 0x1E6F, V gain 0x1CBF and offset 0x877. The R row has V gain 0x662 and offset 0x3211. The B row has U gain 0x812 and offset 0x2EB1. Every other entry is zero. With these values, (Y,U,V)=(16,128,128) gives (0,0,0) and (235,128,128) gives (255,255,255).
- R3: A channel computes c0*Y + c1*U + c2*V + (k << 6) at full precision. Y, U and V are unsigned. The gains c0..c2 are 13-bit two's complement with 10 fraction bits. The offset k is 14-bit two's complement with 4 fraction bits. The sum is rounded half-up by adding 512 and then shifted right arithmetically by 10.
- R4: The rounded result is clamped: a negative value gives 0 and a value above 255 gives 255.
- R5: Coefficient address = 4*row + column. Columns 0, 1 and 2 hold the Y, U and V gains and column 3 holds the offset. Row 0 drives G, row 1 drives R and row 2 drives B. The output ports are R, G, B.
- R6: A write to addresses 12..15 changes no coefficient.
- R7: A pixel accepted with `bypass`=1 gives `out_r`=Y, `out_g`=U and `out_b`=V, whatever the coefficients hold.
- R8: A pixel accepted at clock edge N is shown on the outputs from edge N+2, with `out_valid`=1. This holds in both modes when nothing stalls.
- R9: While `out_valid`=1 and `out_ready`=0, the outputs hold steady and `in_ready` is 0. Pixels leave the block in the order they entered, with none lost and none repeated.
- R10: A gain write keeps bits 12:0 of `cfg_wdata` and ignores bit 13. An offset write keeps all 14 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_y | input | 8 | Luma |
| in_u | input | 8 | Blue-difference chroma |
| in_v | input | 8 | Red-difference chroma |
| bypass | input | 1 | Pass this pixel through unconverted |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient address |
| cfg_wdata | input | 14 | Coefficient value |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the pixel |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
The bench drives pixels that push each channel past both clamp limits. A design that wraps instead of clamping would show small values where the result should be 0 or 255. Offsets of +0.5 and -0.5 target the rounding step, which catches truncation and round-toward-zero. A matrix with one distinct gain per row exposes a swapped row order or a swapped output wiring, and writes that set bit 13 or use addresses 12..15 catch bad sign extension and bad address decoding. A stalled burst checks that the pipeline neither drops pixels nor repeats them, and the stage count is checked on every pixel.

// File: rtl/yuv_rgb_csc_pkg.sv
package yuv_rgb_csc_pkg;

    localparam int N_ROWS   = 3;   // row 0 = G, row 1 = R, row 2 = B
    localparam int N_TAPS   = 3;   // Y, U, V gains per row
    localparam int ROW_G    = 0;
    localparam int ROW_R    = 1;
    localparam int ROW_B    = 2;
    localparam int TBL_W    = 14;

    // Reset matrix, index = 4*row + column, column 3 = offset
    localparam logic [TBL_W-1:0] CSC_BT601 [12] = '{
        14'h04A7, 14'h1E6F, 14'h1CBF, 14'h0877,
        14'h04A7, 14'h0000, 14'h0662, 14'h3211,
        14'h04A7, 14'h0812, 14'h0000, 14'h2EB1
    };

endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
    import yuv_rgb_csc_pkg::*;
#(
    parameter int MAT_W  = 13,
    parameter int OFF_W  = 14,
    parameter int ADDR_W = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       cfg_we,
    input  logic [ADDR_W-1:0]                          cfg_addr,
    input  logic [OFF_W-1:0]                           cfg_wdata,
    output logic [N_ROWS-1:0][N_TAPS-1:0][MAT_W-1:0]   mat_o,
    output logic [N_ROWS-1:0][OFF_W-1:0]               off_o
);

    localparam int RW = ADDR_W - 2;
    localparam logic [RW-1:0] ROW_LIM = RW'(N_ROWS);
    localparam logic [1:0]    OFF_COL = 2'(N_TAPS);

    typedef struct packed {
        logic [N_ROWS-1:0][N_TAPS-1:0][MAT_W-1:0] mat;
        logic [N_ROWS-1:0][OFF_W-1:0]             off;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [RW-1:0] row_sel;
    logic [1:0]    col_sel;

    function automatic bank_t reset_bank();
        bank_t b;
        for (int r = 0; r < N_ROWS; r++) begin
            for (int c = 0; c < N_TAPS; c++) begin
                b.mat[r][c] = CSC_BT601[r*4+c][MAT_W-1:0];
            end
            b.off[r] = CSC_BT601[r*4+3][OFF_W-1:0];
        end
        return b;
    endfunction

    assign row_sel = cfg_addr[ADDR_W-1:2];
    assign col_sel = cfg_addr[1:0];

    always_comb begin
        bank_d = bank_q;
        if (cfg_we && (row_sel < ROW_LIM)) begin
            if (col_sel == OFF_COL) begin
                bank_d.off[row_sel] = cfg_wdata;
            end else begin
                bank_d.mat[row_sel][col_sel] = cfg_wdata[MAT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= reset_bank();
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mat_o = bank_q.mat;
    assign off_o = bank_q.off;

    // R6: out-of-range address leaves the bank untouched
    assert_ignore_high_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !(row_sel < ROW_LIM)) |=> ($stable(mat_o) && $stable(off_o)));

    // R10: an offset write lands with all of its bits
    assert_offset_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (row_sel < ROW_LIM) && (col_sel == OFF_COL))
        |=> (off_o[$past(row_sel)] == $past(cfg_wdata)));

endmodule

// File: rtl/csc_row_mac.sv
module csc_row_mac #(
    parameter int PIX_W = 8,
    parameter int MAT_W = 13,
    parameter int OFF_W = 14,
    parameter int SH    = 6,
    parameter int SUM_W = 24
) (
    input  logic [PIX_W-1:0]        y_i,
    input  logic [PIX_W-1:0]        u_i,
    input  logic [PIX_W-1:0]        v_i,
    input  logic signed [MAT_W-1:0] gy_i,
    input  logic signed [MAT_W-1:0] gu_i,
    input  logic signed [MAT_W-1:0] gv_i,
    input  logic signed [OFF_W-1:0] k_i,
    output logic signed [SUM_W-1:0] sum_o
);

    logic signed [SUM_W-1:0] ye, ue, ve, gye, gue, gve, ke;

    always_comb begin
        ye    = SUM_W'($signed({1'b0, y_i}));
        ue    = SUM_W'($signed({1'b0, u_i}));
        ve    = SUM_W'($signed({1'b0, v_i}));
        gye   = SUM_W'(gy_i);
        gue   = SUM_W'(gu_i);
        gve   = SUM_W'(gv_i);
        ke    = SUM_W'(k_i) <<< SH;
        sum_o = ye * gye + ue * gue + ve * gve + ke;
    end

endmodule

// File: rtl/csc_round_sat.sv
module csc_round_sat #(
    parameter int PIX_W = 8,
    parameter int FRAC  = 10,
    parameter int SUM_W = 24
) (
    input  logic signed [SUM_W-1:0] sum_i,
    output logic [PIX_W-1:0]        pix_o
);

    localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (FRAC - 1);
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

    logic signed [SUM_W-1:0] scaled;

    always_comb begin
        scaled = (sum_i + HALF) >>> FRAC;
        if (scaled < 0) begin
            pix_o = '0;
        end else if (scaled > MAXV) begin
            pix_o = '1;
        end else begin
            pix_o = scaled[PIX_W-1:0];
        end
    end

endmodule

// File: rtl/yuv_rgb_csc.sv
module yuv_rgb_csc
    import yuv_rgb_csc_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int MAT_W    = 13,
    parameter int MAT_FRAC = 10,
    parameter int OFF_W    = 14,
    parameter int OFF_FRAC = 4,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_y,
    input  logic [PIX_W-1:0]  in_u,
    input  logic [PIX_W-1:0]  in_v,
    input  logic              bypass,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [OFF_W-1:0]  cfg_wdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);

    localparam int SH     = MAT_FRAC - OFF_FRAC;
    localparam int PROD_W = MAT_W + PIX_W + 1;
    localparam int OFFS_W = OFF_W + SH;
    localparam int SUM_W  = ((PROD_W > OFFS_W) ? PROD_W : OFFS_W) + 2;

    typedef struct packed {
        logic             vld;
        logic             byp;
        logic [PIX_W-1:0] luma;
        logic [PIX_W-1:0] cb;
        logic [PIX_W-1:0] cr;
    } in_stage_t;

    typedef struct packed {
        logic                           vld;
        logic                           byp;
        logic [PIX_W-1:0]               luma;
        logic [PIX_W-1:0]               cb;
        logic [PIX_W-1:0]               cr;
        logic [N_ROWS-1:0][SUM_W-1:0]   acc;
    } mac_stage_t;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] r;
        logic [PIX_W-1:0] g;
        logic [PIX_W-1:0] b;
    } out_stage_t;

    typedef struct packed {
        in_stage_t  s1;
        mac_stage_t s2;
        out_stage_t s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic  advance;

    logic [N_ROWS-1:0][N_TAPS-1:0][MAT_W-1:0] mat;
    logic [N_ROWS-1:0][OFF_W-1:0]             off;
    logic [N_ROWS-1:0][SUM_W-1:0]             row_sum;
    logic [N_ROWS-1:0][PIX_W-1:0]             row_pix;

    csc_coef_bank #(
        .MAT_W  (MAT_W),
        .OFF_W  (OFF_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mat_o     (mat),
        .off_o     (off)
    );

    for (genvar gr = 0; gr < N_ROWS; gr++) begin : g_row
        csc_row_mac #(
            .PIX_W (PIX_W),
            .MAT_W (MAT_W),
            .OFF_W (OFF_W),
            .SH    (SH),
            .SUM_W (SUM_W)
        ) u_mac (
            .y_i   (pipe_q.s1.luma),
            .u_i   (pipe_q.s1.cb),
            .v_i   (pipe_q.s1.cr),
            .gy_i  ($signed(mat[gr][0])),
            .gu_i  ($signed(mat[gr][1])),
            .gv_i  ($signed(mat[gr][2])),
            .k_i   ($signed(off[gr])),
            .sum_o (row_sum[gr])
        );

        csc_round_sat #(
            .PIX_W (PIX_W),
            .FRAC  (MAT_FRAC),
            .SUM_W (SUM_W)
        ) u_sat (
            .sum_i ($signed(pipe_q.s2.acc[gr])),
            .pix_o (row_pix[gr])
        );
    end

    assign advance = !pipe_q.s3.vld || out_ready;

    always_comb begin
        pipe_d = pipe_q;
        if (advance) begin
            pipe_d.s1.vld  = in_valid;
            pipe_d.s1.byp  = bypass;
            pipe_d.s1.luma = in_y;
            pipe_d.s1.cb   = in_u;
            pipe_d.s1.cr   = in_v;

            pipe_d.s2.vld  = pipe_q.s1.vld;
            pipe_d.s2.byp  = pipe_q.s1.byp;
            pipe_d.s2.luma = pipe_q.s1.luma;
            pipe_d.s2.cb   = pipe_q.s1.cb;
            pipe_d.s2.cr   = pipe_q.s1.cr;
            pipe_d.s2.acc  = row_sum;

            pipe_d.s3.vld  = pipe_q.s2.vld;
            if (pipe_q.s2.byp) begin
                pipe_d.s3.r = pipe_q.s2.luma;
                pipe_d.s3.g = pipe_q.s2.cb;
                pipe_d.s3.b = pipe_q.s2.cr;
            end else begin
                pipe_d.s3.r = row_pix[ROW_R];
                pipe_d.s3.g = row_pix[ROW_G];
                pipe_d.s3.b = row_pix[ROW_B];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign in_ready  = advance;
    assign out_valid = pipe_q.s3.vld;
    assign out_r     = pipe_q.s3.r;
    assign out_g     = pipe_q.s3.g;
    assign out_b     = pipe_q.s3.b;

    // R9: a stalled output holds its value
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

    // R8: three stages without stall move the valid flag through exactly
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_ready, 1) && $past(in_ready, 2) && $past(in_ready, 3))
        |-> (out_valid == $past(in_valid, 3)));

    // R7: bypassed pixel reaches the outputs unchanged
    assert_bypass_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_ready, 1) && $past(in_ready, 2) && $past(in_ready, 3) &&
         $past(in_valid && bypass, 3))
        |-> (out_r == $past(in_y, 3) && out_g == $past(in_u, 3) && out_b == $past(in_v, 3)));

endmodule

// File: tb/yuv_rgb_csc_test.sv
module yuv_rgb_csc_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_y = '0, in_u = '0, in_v = '0;
    logic       bypass = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [13:0] cfg_wdata = '0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_r, out_g, out_b;

    int n_checks = 0;
    int n_fail   = 0;
    int bc [12];

    always #(CLK_PERIOD/2) clk = ~clk;

    yuv_rgb_csc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_y      (in_y),
        .in_u      (in_u),
        .in_v      (in_v),
        .bypass    (bypass),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_r     (out_r),
        .out_g     (out_g),
        .out_b     (out_b)
    );

    // stimulus {Y, U, V, bypass}
    localparam logic [24:0] VEC [10] = '{
        {8'd16,  8'd128, 8'd128, 1'b0},
        {8'd235, 8'd128, 8'd128, 1'b0},
        {8'd81,  8'd90,  8'd240, 1'b0},
        {8'd145, 8'd54,  8'd34,  1'b0},
        {8'd41,  8'd240, 8'd110, 1'b0},
        {8'd0,   8'd0,   8'd0,   1'b0},
        {8'd255, 8'd255, 8'd255, 1'b0},
        {8'd120, 8'd200, 8'd60,  1'b1},
        {8'd126, 8'd128, 8'd130, 1'b0},
        {8'd3,   8'd250, 8'd7,   1'b1}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model(input int row, input int y, input int u, input int v);
        int s;
        s = bc[row*4] * y + bc[row*4+1] * u + bc[row*4+2] * v + bc[row*4+3] * 64;
        s = (s + 512) >>> 10;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    task automatic wr(input int addr, input logic [13:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 12) begin
            if ((addr % 4) == 3) bc[addr] = int'($signed(data));
            else                 bc[addr] = int'($signed(data[12:0]));
        end
    endtask

    // one pixel, with the R8 stage count checked on the way
    task automatic push(input logic [7:0] y, input logic [7:0] u, input logic [7:0] v,
                        input logic b, output int r, output int g, output int bo);
        logic l0, l1, l2;
        @(negedge clk);
        in_y = y; in_u = u; in_v = v; bypass = b; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        l0 = out_valid;
        @(posedge clk);
        @(negedge clk);
        l1 = out_valid;
        @(posedge clk);
        @(negedge clk);
        l2 = out_valid;
        r = int'(out_r); g = int'(out_g); bo = int'(out_b);
        check("R8 valid after 1 edge", int'(l0), 0);
        check("R8 valid after 2 edges", int'(l1), 0);
        check("R8 valid after 3 edges", int'(l2), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int r, g, b;
        int acc;
        logic rdy;
        bc = '{1191, -401, -833, 2167, 1191, 0, 1634, -3567, 1191, 2066, 0, -4431};

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
        check("R1 in_ready after reset", int'(in_ready), 1);

        // R2: defaults, black and white
        push(8'd16, 8'd128, 8'd128, 1'b0, r, g, b);
        check("R2 black R", r, 0); check("R2 black G", g, 0); check("R2 black B", b, 0);
        push(8'd235, 8'd128, 8'd128, 1'b0, r, g, b);
        check("R2 white R", r, 255); check("R2 white G", g, 255); check("R2 white B", b, 255);

        // R4: clamp at both ends
        push(8'd16, 8'd16, 8'd240, 1'b0, r, g, b);
        check("R4 mid R", r, 179); check("R4 low G", g, 0); check("R4 low B", b, 0);
        push(8'd235, 8'd240, 8'd16, 1'b0, r, g, b);
        check("R4 mid R", r, 76); check("R4 high G", g, 255); check("R4 high B", b, 255);

        // R3 / R7 vector table against the equation
        for (int i = 0; i < 10; i++) begin
            logic [24:0] e;
            e = VEC[i];
            push(e[24:17], e[16:9], e[8:1], e[0], r, g, b);
            if (e[0]) begin
                check("R7 table R", r, int'(e[24:17]));
                check("R7 table G", g, int'(e[16:9]));
                check("R7 table B", b, int'(e[8:1]));
            end else begin
                check("R3 table R", r, model(1, int'(e[24:17]), int'(e[16:9]), int'(e[8:1])));
                check("R3 table G", g, model(0, int'(e[24:17]), int'(e[16:9]), int'(e[8:1])));
                check("R3 table B", b, model(2, int'(e[24:17]), int'(e[16:9]), int'(e[8:1])));
            end
        end

        // R5: one distinct unit gain per row
        wr(0, 14'd0);    wr(1, 14'd1024); wr(2, 14'd0);    wr(3, 14'd0);
        wr(4, 14'd1024); wr(5, 14'd0);    wr(6, 14'd0);    wr(7, 14'd0);
        wr(8, 14'd0);    wr(9, 14'd0);    wr(10, 14'd1024); wr(11, 14'd0);
        push(8'd10, 8'd20, 8'd30, 1'b0, r, g, b);
        check("R5 R from Y", r, 10); check("R5 G from U", g, 20); check("R5 B from V", b, 30);

        // R3: rounding of exact halves
        wr(7, 14'd8);
        push(8'd10, 8'd20, 8'd30, 1'b0, r, g, b);
        check("R3 plus half rounds up", r, 11);
        wr(7, 14'h3FF8);
        push(8'd10, 8'd20, 8'd30, 1'b0, r, g, b);
        check("R3 minus half rounds up", r, 10);
        wr(7, 14'd0);

        // R10: gain ignores bit 13, offset keeps 14 bits
        wr(0, 14'h2000);
        push(8'd10, 8'd20, 8'd30, 1'b0, r, g, b);
        check("R10 gain bit13 ignored", g, 20);
        wr(3, 14'd64);
        push(8'd10, 8'd20, 8'd30, 1'b0, r, g, b);
        check("R10 offset write", g, 24);

        // R6: high addresses write nothing
        for (int a = 12; a < 16; a++) wr(a, 14'h1555);
        push(8'd10, 8'd20, 8'd30, 1'b0, r, g, b);
        check("R6 R unchanged", r, 10); check("R6 G unchanged", g, 24); check("R6 B unchanged", b, 30);

        // R7: bypass with a custom matrix loaded
        push(8'd200, 8'd17, 8'd99, 1'b1, r, g, b);
        check("R7 bypass R", r, 200); check("R7 bypass G", g, 17); check("R7 bypass B", b, 99);

        // R9: back-pressure, fill and drain
        @(negedge clk);
        out_ready = 1'b0;
        acc = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_valid = 1'b1; bypass = 1'b1;
            in_y = 8'(40 + acc); in_u = 8'(50 + acc); in_v = 8'(60 + acc);
            rdy = in_ready;
            @(posedge clk);
            if (rdy) acc++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 accepted while stalled", acc, 3);
        check("R9 in_ready low on stall", int'(in_ready), 0);
        check("R9 head pixel", int'(out_r), 40);
        @(posedge clk);
        @(negedge clk);
        check("R9 held output", int'(out_r), 40);
        check("R9 held valid", int'(out_valid), 1);
        out_ready = 1'b1;
        for (int j = 0; j < 3; j++) begin
            check("R9 drain valid", int'(out_valid), 1);
            check("R9 drain order R", int'(out_r), 40 + j);
            check("R9 drain order B", int'(out_b), 60 + j);
            @(posedge clk);
            @(negedge clk);
        end
        check("R9 no duplicate", int'(out_valid), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule